// File: doc/BRIEF.md
# Open-Drain Data Line Repeater

This block joins two open-drain data wires: one toward the controller (host side) and one toward the smart card (card side). Both wires idle high on their pull-up resistors. When one side pulls its wire low, the repeater copies that low onto the other wire. The side whose falling edge is seen first becomes the master for that bit. The opposite wire is the slave: the repeater drives it low, and its own falling edges are ignored until the bit ends. Without this lockout, the echo of the repeater's own pull-down would capture the link.

When the master releases its wire, the repeater drops the slave pull-down and turns on a short active pull-up on the slave wire. This gives a fast rising edge. When the pulse ends, the repeater returns to idle and waits for the next first falling edge. Both the propagation delay and the pulse length are a whole number of system clock cycles, set by one parameter. The session sequencer can hold the repeater in idle with a single input.

The block only sees the sampled wire levels. It outputs a pull-down enable and an active pull-up enable for each wire. The resistors and analog drivers are outside the block.

Top module: `odline_repeater`

## Requirements
- R1: During reset and directly after it, all four drive enables (`host_pd_o`, `host_pu_o`, `card_pd_o`, `card_pu_o`) are 0.
- R2: When the host wire falls while the repeater is idle, the host side becomes master. `card_pd_o` rises after the (DELAY_CYC+3)-th rising clock edge counted from the input change, and is still 0 after the (DELAY_CYC+2)-th. Both host-side drives stay 0.
- R3: When the card wire falls first, the card side becomes master. `host_pd_o` follows with the same DELAY_CYC+3 edge latency, and both card-side drives stay 0.
- R4: When both wires fall in the same cycle, the host side is master. The card wire is the one pulled low.
- R5: While a master is held, falling edges on the slave wire elect nothing and change no drive. This covers the repeater's own echo and extra pulses from the far side. At no time does the repeater drive both wires.
- R6: After the master wire returns high, the slave pull-down drops and the slave pull-up turns on, both after the 3rd rising edge. The pull-up stays on for exactly DELAY_CYC cycles. After that, all drives are 0 and the repeater is idle.
- R7: A pull-down enable and a pull-up enable are never 1 together on the same wire.
- R8: If the master wire returns high before the propagation delay has run out, no pull-down and no pull-up is driven, and the repeater returns to idle.
- R9: While `hold_idle` is 1, all drive enables are 0 from the first rising edge on. No master is elected. A wire that is still low when `hold_idle` falls back to 0 does not start a transfer.
- R10: Back-to-back bits at a 1 MHz rate (125 clock cycles per bit, about half low), alternating master side, each repeat with the R2/R3 and R6 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_idle | input | 1 | Forces idle and all drives off while 1 |
| host_line_i | input | 1 | Sampled level of the host-side wire |
| card_line_i | input | 1 | Sampled level of the card-side wire |
| host_pd_o | output | 1 | Pull-down enable for the host-side wire |
| host_pu_o | output | 1 | Active pull-up enable for the host-side wire |
| card_pd_o | output | 1 | Pull-down enable for the card-side wire |
| card_pu_o | output | 1 | Active pull-up enable for the card-side wire |

## Verification
Each result has a fixed due cycle with the default two-stage synchroniser:

- **Slave pull-down:** due after edge DELAY_CYC+3 following a fall. The bench checks one edge early that it is still 0, then on time that it is 1.
- **Pull-down drop and pull-up:** both due after edge 3 following the master's release. The pull-up ends after edge DELAY_CYC+3.
- **Hold:** clears every drive after one edge.

The bench drives its inputs and samples the outputs on falling clock edges. It counts rising edges from each stimulus before every comparison. The wire levels it feeds back combine its own drive with the repeater's pull-downs, so the echo on the slave wire is present as it would be on the board.

// File: rtl/odrep_pkg.sv
package odrep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROP  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_PULSE = 2'd3
    } rep_state_e;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } rep_side_e;

    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/odrep_sync.sv
module odrep_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    assign pipe_d[0] = d_i;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            assign pipe_d[s] = pipe_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/odrep_fall.sv
module odrep_fall #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/odline_repeater.sv
module odline_repeater
    import odrep_pkg::*;
#(
    parameter int DELAY_CYC   = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_idle,
    input  logic host_line_i,
    input  logic card_line_i,
    output logic host_pd_o,
    output logic host_pu_o,
    output logic card_pd_o,
    output logic card_pu_o
);

    localparam int            CNT_W    = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC - 1);

    typedef struct packed {
        rep_state_e      state;
        rep_side_e       master;
        logic [CNT_W-1:0] cnt;
    } rep_reg_t;

    logic [NUM_SIDES-1:0] line_raw;
    logic [NUM_SIDES-1:0] line_lvl;
    logic [NUM_SIDES-1:0] line_fall;
    logic                 master_high;
    logic                 slave_pd;
    logic                 slave_pu;

    rep_reg_t r_d;
    rep_reg_t r_q;

    assign line_raw = {card_line_i, host_line_i};

    odrep_sync #(
        .WIDTH (NUM_SIDES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (line_raw),
        .q_o  (line_lvl)
    );

    odrep_fall #(
        .WIDTH(NUM_SIDES)
    ) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (line_lvl),
        .fall_o(line_fall)
    );

    assign master_high = (r_q.master == SIDE_HOST) ? line_lvl[0] : line_lvl[1];

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                // host side wins a tie
                if (line_fall[0]) begin
                    r_d.state  = ST_PROP;
                    r_d.master = SIDE_HOST;
                    r_d.cnt    = CNT_LOAD;
                end else if (line_fall[1]) begin
                    r_d.state  = ST_PROP;
                    r_d.master = SIDE_CARD;
                    r_d.cnt    = CNT_LOAD;
                end
            end
            ST_PROP: begin
                if (master_high) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == '0) begin
                    r_d.state = ST_DRIVE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_DRIVE: begin
                if (master_high) begin
                    r_d.state = ST_PULSE;
                    r_d.cnt   = CNT_LOAD;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cnt   = '0;
            end
        endcase
        if (hold_idle) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, master: SIDE_HOST, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign slave_pd  = (r_q.state == ST_DRIVE);
    assign slave_pu  = (r_q.state == ST_PULSE);
    assign card_pd_o = slave_pd && (r_q.master == SIDE_HOST);
    assign card_pu_o = slave_pu && (r_q.master == SIDE_HOST);
    assign host_pd_o = slave_pd && (r_q.master == SIDE_CARD);
    assign host_pu_o = slave_pu && (r_q.master == SIDE_CARD);

    // R7
    pd_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pd_o && host_pu_o) && !(card_pd_o && card_pu_o));

    // R5
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((host_pd_o || host_pu_o) && (card_pd_o || card_pu_o)));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_idle) |-> !(host_pd_o || host_pu_o || card_pd_o || card_pu_o));

    // R6
    card_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pu_o) |-> $fell(card_pd_o));

    // R6
    host_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pu_o) |-> $fell(host_pd_o));

    // R2
    card_pd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pd_o) |-> !line_lvl[0]);

endmodule

// File: tb/odline_repeater_bench.sv
module odline_repeater_bench;

    localparam int D = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_idle = 1'b0;
    logic host_ext = 1'b1;
    logic card_ext = 1'b1;
    logic host_line, card_line;
    logic host_pd, host_pu, card_pd, card_pu;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign host_line = host_ext & ~host_pd;
    assign card_line = card_ext & ~card_pd;

    odline_repeater #(.DELAY_CYC(D), .SYNC_STAGES(2)) u_odline_repeater (
        .clk(clk), .rst_n(rst_n), .hold_idle(hold_idle),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pd_o(host_pd), .host_pu_o(host_pu),
        .card_pd_o(card_pd), .card_pu_o(card_pu)
    );

    function automatic int lat_pd();   return D + 3; endfunction
    function automatic int lat_pu_on(); return 3;    endfunction
    function automatic int lat_pu_off(); return D + 3; endfunction

    function automatic logic [3:0] all_drv();
        return {host_pd, host_pu, card_pd, card_pu};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_quiet(input int n, input string req);
        bit bad = 1'b0;
        logic [3:0] seen = '0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (all_drv() != 4'b0) begin bad = 1'b1; seen = all_drv(); end
        end
        chk(!bad, req, int'(seen), 0);
    endtask

    // one bit: card_master selects side, both = tie, poke = extra slave pulse
    task automatic xfer(input bit card_master, input int low_len, input bit both,
                        input bit poke, input string req);
        logic s_pd, s_pu, m_drv;
        bit mbad = 1'b0;
        bit sbad = 1'b0;
        if (card_master) card_ext = 1'b0; else host_ext = 1'b0;
        if (both) begin host_ext = 1'b0; card_ext = 1'b0; end
        for (int k = 1; k <= low_len; k++) begin
            tick();
            s_pd  = card_master ? host_pd : card_pd;
            m_drv = card_master ? (card_pd | card_pu) : (host_pd | host_pu);
            if (m_drv) mbad = 1'b1;
            if (k == lat_pd() - 1) chk(s_pd == 1'b0, {req, " pd early"}, s_pd, 0);
            if (k == lat_pd())     chk(s_pd == 1'b1, {req, " pd due"}, s_pd, 1);
            if (k > lat_pd() && s_pd != 1'b1) sbad = 1'b1;
            if (poke && k == lat_pd() + 3) begin
                if (card_master) host_ext = 1'b0; else card_ext = 1'b0;
            end
            if (poke && k == lat_pd() + 7) begin
                if (card_master) host_ext = 1'b1; else card_ext = 1'b1;
            end
        end
        chk(!mbad, {req, " master side undriven"}, mbad, 0);
        chk(!sbad, {req, " R5 slave pd held"}, sbad, 0);
        host_ext = 1'b1;
        card_ext = 1'b1;
        mbad = 1'b0;
        for (int k = 1; k <= lat_pu_off() + 1; k++) begin
            tick();
            s_pd  = card_master ? host_pd : card_pd;
            s_pu  = card_master ? host_pu : card_pu;
            m_drv = card_master ? (card_pd | card_pu) : (host_pd | host_pu);
            if (m_drv) mbad = 1'b1;
            if (k == lat_pu_on() - 1)
                chk(s_pd && !s_pu, {req, " R6 before release"}, {s_pd, s_pu}, 2);
            if (k == lat_pu_on())
                chk(!s_pd && s_pu, {req, " R6 pulse start"}, {s_pd, s_pu}, 1);
            if (k == lat_pu_off() - 1)
                chk(!s_pd && s_pu, {req, " R6 pulse last"}, {s_pd, s_pu}, 1);
            if (k >= lat_pu_off())
                chk(all_drv() == 4'b0, {req, " R6 idle"}, all_drv(), 0);
        end
        chk(!mbad, {req, " R5 release master undriven"}, mbad, 0);
    endtask

    initial begin
        void'($urandom(32'h0D1E_5EED));
        repeat (3) @(negedge clk);
        chk(all_drv() == 4'b0, "R1 in reset", all_drv(), 0);
        rst_n = 1'b1;
        idle_quiet(5, "R1 after reset");

        xfer(1'b0, D + 20, 1'b0, 1'b0, "R2 host master");
        idle_quiet(10, "R2 gap");
        xfer(1'b1, D + 20, 1'b0, 1'b0, "R3 card master");
        idle_quiet(10, "R3 gap");
        xfer(1'b0, D + 20, 1'b1, 1'b0, "R4 tie");
        idle_quiet(10, "R4 gap");
        xfer(1'b0, D + 20, 1'b0, 1'b1, "R5 host lockout");
        idle_quiet(10, "R5 gap");
        xfer(1'b1, D + 20, 1'b0, 1'b1, "R5 card lockout");
        idle_quiet(10, "R5 gap2");

        // R8 short low
        host_ext = 1'b0;
        repeat (5) tick();
        host_ext = 1'b1;
        idle_quiet(40, "R8 short low no drive");
        card_ext = 1'b0;
        repeat (D) tick();
        card_ext = 1'b1;
        idle_quiet(40, "R8 card short low no drive");

        // R9 hold during drive
        host_ext = 1'b0;
        repeat (lat_pd()) tick();
        chk(card_pd == 1'b1, "R9 setup pd", card_pd, 1);
        hold_idle = 1'b1;
        tick();
        chk(all_drv() == 4'b0, "R9 hold clears", all_drv(), 0);
        idle_quiet(10, "R9 held");
        hold_idle = 1'b0;
        idle_quiet(10, "R9 low line no restart");
        host_ext = 1'b1;
        idle_quiet(10, "R9 after release");
        // R9 hold blocks election
        hold_idle = 1'b1;
        card_ext = 1'b0;
        idle_quiet(40, "R9 no election held");
        hold_idle = 1'b0;
        idle_quiet(20, "R9 no election after");
        card_ext = 1'b1;
        idle_quiet(10, "R9 tail");

        // R10 1 MHz stream, alternating sides
        for (int i = 0; i < 10; i++) begin
            xfer(i[0], 62, 1'b0, 1'b0, "R10 stream");
            repeat (125 - 62 - (lat_pu_off() + 1)) tick();
        end

        // random mix
        for (int i = 0; i < 30; i++) begin
            int len = $urandom_range(62, D + 12);
            bit side = 1'($urandom_range(1, 0));
            bit pk = 1'($urandom_range(1, 0));
            xfer(side, len, 1'b0, pk, side ? "R3 random" : "R2 random");
            idle_quiet($urandom_range(40, 8), "R5 random gap");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule